// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel

This block is a single channel of a programmable interval timer. A load strobe captures a 16-bit count N and a 3-bit mode. It also clears an elapsed-tick counter d. After that, d advances by one on each timer-clock tick (a one-cycle `tick_en` pulse in the system clock domain) while the channel's gate is high.

The single output bit is a pure function of d and N, chosen by the mode:

- a terminal-count level;
- an inverted terminal-count level;
- a rate pulse;
- a square wave;
- a one-tick strobe.

A count of zero stands for 65536. Mode values 6 and 7 act like mode 0.

To avoid a divider, a second counter holds the remainder d mod N. It wraps to zero at N. A status word gives the loaded mode, the registered gate and the output.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is in mode 3 with an effective count of 65536, d = 0, and the registered gate equal to parameter GATE_RST (default 1). With the default, the status is 5'b01111 and `out_bit` is 1.
- R2: On a clock edge with `load_stb` high, the channel stores `load_mode` and `load_count`, where a count of 0 is stored as 65536. d and the remainder are cleared to 0. A load takes precedence over a tick on the same edge.
- R3: d advances by exactly one on each edge where `tick_en` is high and the registered gate is high. On every other edge it holds. `out_bit` reflects the new d right after that edge.
- R4: Mode 0: `out_bit` is 0 while d < N and 1 once d >= N. It stays 1 until the next load.
- R5: Mode 1: `out_bit` is 1 while d < N and 0 once d >= N.
- R6: Mode 2: `out_bit` is 1 exactly when d is nonzero and d mod N = 0. Otherwise it is 0.
- R7: Mode 3: `out_bit` is 1 while (d mod N) < (N+1)/2, using integer division. Otherwise it is 0.
- R8: Modes 4 and 5: `out_bit` is 1 only while d = N.
- R9: Loaded mode values 6 and 7 produce the mode 0 output rule.
- R10: `gate_in` is registered on every clock. While the registered gate is 0, ticks are not counted and `out_bit` holds.
- R11: The status word is laid out as follows: bits [4:2] hold the loaded mode value exactly as written, bit 1 holds the registered gate, and bit 0 holds `out_bit`.
- R12: d saturates instead of wrapping. A one-shot output therefore never fires a second time without a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Marks one timer-clock tick |
| load_stb | input | 1 | Load a new count and mode |
| load_count | input | 16 | Count N; 0 means 65536 |
| load_mode | input | 3 | Output rule selector |
| gate_in | input | 1 | Gate; counting is enabled while high |
| out_bit | output | 1 | Channel output |
| status_o | output | 5 | {mode, registered gate, out_bit} |

## Verification
Every result is due in the cycle after the edge that causes it:

- A load or a tick changes `out_bit` and the status directly after that edge, because the output is combinational from registers.
- A change on `gate_in` takes effect one edge later, through the gate register. Only ticks on later edges are affected.

The bench drives inputs on falling edges and samples one falling edge after each load or tick. A reference model of d and N, computed with a true modulo, predicts the output for every tick across all eight mode values and six counts. Extra idle cycles confirm that the output holds without a tick. A directed run takes a zero count through 65536 ticks and past them, to show that the strobe fires once.

// File: rtl/pit_pkg.sv
package pit_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      PIT_TERM     = 3'd0,
      PIT_RETRIG   = 3'd1,
      PIT_RATE     = 3'd2,
      PIT_SQUARE   = 3'd3,
      PIT_SWSTROBE = 3'd4,
      PIT_HWSTROBE = 3'd5
   } pit_mode_e;

   // values above the last defined rule fall back to the terminal-count rule
   function automatic pit_mode_e pit_eff_mode(logic [MODE_W-1:0] raw);
      if (raw > 3'd5) return PIT_TERM;
      return pit_mode_e'(raw);
   endfunction

endpackage

// File: rtl/pit_elapsed.sv
module pit_elapsed #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] d_o
);
   localparam logic [W-1:0] MAX = {W{1'b1}};
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] d_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 d_q <= '0;
      else if (clr)               d_q <= '0;
      else if (step && d_q != MAX) d_q <= d_q + ONE;
   end

   assign d_o = d_q;

   a_r2_elapsed_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> d_q == '0);
   a_r3_elapsed_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && d_q != MAX) |=> d_q == $past(d_q) + ONE);
   a_r3_elapsed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(d_q));
   a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (d_q == MAX && !clr) |=> d_q == MAX);

endmodule

// File: rtl/pit_phase.sv
module pit_phase #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] n_i,
   output logic [W-1:0] r_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] r_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     r_q <= '0;
      else if (clr)   r_q <= '0;
      else if (step) begin
         if (r_q == n_i - ONE) r_q <= '0;
         else                  r_q <= r_q + ONE;
      end
   end

   assign r_o = r_q;

   a_r7_phase_below_n: assert property (@(posedge clk) disable iff (!rst_n)
      r_q < n_i);
   a_r2_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> r_q == '0);

endmodule

// File: rtl/pit_outsel.sv
module pit_outsel
   import pit_pkg::*;
#(
   parameter int W = 17
) (
   input  pit_mode_e    mode_i,
   input  logic [W-1:0] n_i,
   input  logic [W-1:0] d_i,
   input  logic [W-1:0] r_i,
   output logic         out_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] half_w;
   assign half_w = (n_i + ONE) >> 1;

   always_comb begin
      unique case (mode_i)
         PIT_TERM:     out_o = (d_i >= n_i);
         PIT_RETRIG:   out_o = (d_i < n_i);
         PIT_RATE:     out_o = (r_i == '0) && (d_i != '0);
         PIT_SQUARE:   out_o = (r_i < half_w);
         PIT_SWSTROBE,
         PIT_HWSTROBE: out_o = (d_i == n_i);
         default:      out_o = (d_i >= n_i);
      endcase
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int   CNT_W    = 16,
   parameter logic GATE_RST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                load_stb,
   input  logic [CNT_W-1:0]    load_count,
   input  logic [MODE_W-1:0]   load_mode,
   input  logic                gate_in,
   output logic                out_bit,
   output logic [MODE_W+1:0]   status_o
);
   localparam int             ELAP_W = CNT_W + 1;
   localparam logic [ELAP_W-1:0] FULL_N = {1'b1, {CNT_W{1'b0}}};

   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt_w
      $error("pit_channel: CNT_W must lie in 2..30");
   end

   logic [MODE_W-1:0] mode_q;
   logic [ELAP_W-1:0] n_q;
   logic              gate_q;
   logic              step;
   logic [ELAP_W-1:0] d_w;
   logic [ELAP_W-1:0] r_w;
   pit_mode_e         eff_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 3'd3;
         n_q    <= FULL_N;
         gate_q <= GATE_RST;
      end else begin
         gate_q <= gate_in;
         if (load_stb) begin
            mode_q <= load_mode;
            n_q    <= (load_count == '0) ? FULL_N : {1'b0, load_count};
         end
      end
   end

   assign step     = tick_en & gate_q & ~load_stb;
   assign eff_mode = pit_eff_mode(mode_q);

   pit_elapsed #(.W(ELAP_W)) elapsed_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (load_stb),
      .step (step),
      .d_o  (d_w)
   );

   pit_phase #(.W(ELAP_W)) phase_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (load_stb),
      .step (step),
      .n_i  (n_q),
      .r_o  (r_w)
   );

   pit_outsel #(.W(ELAP_W)) outsel_i (
      .mode_i(eff_mode),
      .n_i   (n_q),
      .d_i   (d_w),
      .r_i   (r_w),
      .out_o (out_bit)
   );

   assign status_o = {mode_q, gate_q, out_bit};

   a_r4_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode == PIT_TERM && out_bit && !load_stb) |=> out_bit);
   a_r5_retrig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode == PIT_RETRIG && !out_bit && !load_stb) |=> !out_bit);
   a_r8_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ((eff_mode == PIT_SWSTROBE || eff_mode == PIT_HWSTROBE) && out_bit &&
       tick_en && gate_q && !load_stb) |=> !out_bit);
   a_r10_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_q && !load_stb) |=> $stable(out_bit));
   a_r2_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && load_count == '0) |=> n_q == FULL_N);

endmodule

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en;
   logic        load_stb;
   logic [15:0] load_count;
   logic [2:0]  load_mode;
   logic        gate_in;
   logic        out_bit;
   logic [4:0]  status_o;

   always #4 clk = ~clk;

   pit_channel dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .load_stb  (load_stb),
      .load_count(load_count),
      .load_mode (load_mode),
      .gate_in   (gate_in),
      .out_bit   (out_bit),
      .status_o  (status_o)
   );

   int checks   = 0;
   int failures = 0;
   int ref_mode, ref_n, ref_d;
   logic ref_gate;

   localparam int COUNTS [0:5] = '{1, 2, 3, 7, 10, 0};

   function automatic logic exp_out(int m, int n, int d);
      int mm;
      mm = (m > 5) ? 0 : m;
      case (mm)
         0: return d >= n;
         1: return d < n;
         2: return (d != 0) && (d % n == 0);
         3: return (d % n) < ((n + 1) / 2);
         default: return d == n;
      endcase
   endfunction

   function automatic string rq_of(int m);
      case (m)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         4, 5: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check_now(string rq);
      logic e;
      logic [4:0] es;
      e  = exp_out(ref_mode, ref_n, ref_d);
      es = {ref_mode[2:0], ref_gate, e};
      checks++;
      if (out_bit !== e) begin
         failures++;
         $display("FAIL %s out_bit=%0b expected=%0b (mode=%0d n=%0d d=%0d)",
                  rq, out_bit, e, ref_mode, ref_n, ref_d);
      end
      checks++;
      if (status_o !== es) begin
         failures++;
         $display("FAIL R11 status=%b expected=%b", status_o, es);
      end
   endtask

   task automatic do_load(int m, int c, logic with_tick);
      load_stb   = 1'b1;
      load_mode  = m[2:0];
      load_count = c[15:0];
      tick_en    = with_tick;
      @(negedge clk);
      load_stb = 1'b0;
      tick_en  = 1'b0;
      ref_mode = m;
      ref_n    = (c == 0) ? 65536 : c;
      ref_d    = 0;
   endtask

   task automatic do_tick();
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (ref_gate && ref_d < 131071) ref_d++;
   endtask

   task automatic set_gate(logic v);
      gate_in = v;
      @(negedge clk);
      ref_gate = v;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick_en = 1'b0; load_stb = 1'b0;
      load_count = '0; load_mode = '0; gate_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ref_mode = 3; ref_n = 65536; ref_d = 0; ref_gate = 1'b1;

      // R1: reset state
      checks++;
      if (status_o !== 5'b01111 || out_bit !== 1'b1) begin
         failures++;
         $display("FAIL R1 status=%b out_bit=%0b expected=01111 1", status_o, out_bit);
      end
      for (int k = 0; k < 4; k++) begin
         do_tick();
         check_now("R1");
      end

      // table walk: every mode value against every count, with idle gaps (R3)
      for (int m = 0; m < 8; m++) begin
         for (int ci = 0; ci < 6; ci++) begin
            int nt;
            do_load(m, COUNTS[ci], 1'b0);
            check_now("R2");
            nt = (COUNTS[ci] == 0) ? 40 : 3 * COUNTS[ci] + 3;
            for (int k = 0; k < nt; k++) begin
               do_tick();
               check_now(rq_of(m));
               if (k % 3 == 1) begin
                  @(negedge clk);
                  check_now("R3");
               end
            end
         end
      end

      // R2: a load wins over a tick on the same edge
      do_load(0, 1, 1'b1);
      check_now("R2");
      do_tick();
      check_now("R2");

      // R10: low gate freezes the count
      do_load(0, 3, 1'b0);
      do_tick();
      check_now("R10");
      set_gate(1'b0);
      check_now("R10");
      for (int k = 0; k < 5; k++) begin
         do_tick();
         check_now("R10");
      end
      set_gate(1'b1);
      for (int k = 0; k < 3; k++) begin
         do_tick();
         check_now("R10");
      end

      // R2 and R12: zero count is 65536; the strobe fires once only
      do_load(4, 0, 1'b0);
      check_now("R2");
      for (int k = 0; k < 65556; k++) begin
         do_tick();
         check_now((k >= 65536) ? "R12" : "R2");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule